// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Silence Timeout

This block holds received bytes for a UART until software fetches them. It is a 16-entry byte queue. Bytes enter on a push strobe and leave when a read of the data register pops the head. Around the queue it keeps sticky status levels: empty, full, overrun, trigger reached and timeout. When a status level is set, the block also raises a single-cycle event pulse on a separate output, so that a downstream interrupt unit can latch it. The interrupt unit owns masking and clearing of its own causes.

The trigger threshold is a register inside the block, written through a strobe. A silence timer measures idle time on the receive side. It reloads to four character times on every byte that is stored, and it fires when it runs out. The character time is an input giving clock cycles per character. A receive-path reset pulse empties the queue and clears the error and timeout state. An enable input freezes the queue when it is low.

Top module: `uart_rxq`

## Requirements
- R1: After reset: empty_o=1; full_o, overrun_o, trig_o and timeout_o are 0; all event outputs are 0; pop_data_o=0. The trigger level resets to 32.
- R2: Bytes leave in the order they were stored. pop_data_o always shows the oldest stored byte, and a pop (enable_i=1, pop_i=1) removes it at the next clock edge.
- R3: A push when the queue holds 16 bytes stores nothing. It sets overrun_o and pulses overrun_ev_o for one cycle. A pop in the same cycle does not make room for that byte, and the overrun flag still ends up set.
- R4: A push that brings the occupancy to 16 sets full_o and pulses full_ev_o.
- R5: After a stored push, trig_o is set and trig_ev_o is pulsed if the new occupancy is greater than or equal to the trigger level.
- R6: After a pop, trig_o is cleared if the occupancy is below the trigger level.
- R7: Any enabled pop clears full_o and overrun_o. A pop that leaves the occupancy at 0, or a pop while already empty, sets empty_o. A stored push clears empty_o.
- R8: A pop from an empty queue returns 0: pop_data_o is 0 whenever the queue is empty.
- R9: Every stored push reloads the silence timer to 4*char_time_i cycles. timeout_o is set, and timeout_ev_o pulses, exactly 4*char_time_i cycles after the last stored push. If char_time_i=0 the timer does not start. The timer is idle after reset and after a path reset.
- R10: path_rst_i=1 empties the queue at the next edge. It sets empty_o, clears full_o, overrun_o, trig_o and timeout_o, stops the timer, and overrides any push or pop in that cycle.
- R11: While enable_i=0, push_i and pop_i have no effect on the contents, occupancy or status levels.
- R12: A push and a pop in the same cycle, with occupancy between 1 and 15, leave the occupancy unchanged. The popped byte is the old head, and the pushed byte joins the tail.
- R13: lvl_wr_i=1 loads lvl_i into the trigger level at the clock edge. A push in that same cycle is compared against the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Receive path enable |
| path_rst_i | input | 1 | Receive-path reset pulse |
| push_i | input | 1 | Store push_data_i |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Data-register read strobe |
| pop_data_o | output | 8 | Head byte, 0 when empty |
| lvl_wr_i | input | 1 | Trigger level write strobe |
| lvl_i | input | 6 | New trigger level |
| char_time_i | input | 16 | Clock cycles per character |
| empty_o | output | 1 | Empty level |
| full_o | output | 1 | Full level |
| overrun_o | output | 1 | Overrun level |
| trig_o | output | 1 | Trigger reached level |
| timeout_o | output | 1 | Silence timeout level |
| full_ev_o | output | 1 | Full event pulse |
| overrun_ev_o | output | 1 | Overrun event pulse |
| trig_ev_o | output | 1 | Trigger event pulse |
| timeout_ev_o | output | 1 | Timeout event pulse |

## Verification
The bench goes after the following corner cases:
- Push and pop together on a full queue. A design that lets the pop rescue the push would store a 16th byte and lose the overrun.
- Popping an empty queue. A design that gets this wrong returns stale data or moves the read pointer, which corrupts later ordering.
- Raising the trigger level to the reset value of 32, so that no occupancy can reach it. A design that clips the compare at the queue width would trigger anyway.
- The exact cycle the timeout fires, including the timer staying idle after a path reset. An off-by-one count, or a timer that keeps running, shows up there.

All of this runs alongside long random traffic that also covers disabled cycles and the same-cycle push and pop.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned RXQ_DEPTH  = 16;
  localparam int unsigned RXQ_DATA_W = 8;
  localparam int unsigned RXQ_LVL_W  = 6;
  localparam int unsigned RXQ_CT_W   = 16;
  localparam int unsigned RXQ_LVL_RST = 32;

  typedef struct packed {
    logic empty;
    logic full;
    logic ovr;
    logic trig;
  } rxq_stat_t;

  typedef struct packed {
    logic full;
    logic ovr;
    logic trig;
  } rxq_ev_t;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = RXQ_DEPTH,
  parameter int unsigned DATA_W = RXQ_DATA_W,
  parameter int unsigned LVL_W  = RXQ_LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              push_ok_o,
  output rxq_stat_t         stat_o,
  output rxq_ev_t           ev_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic              full_now, empty_now, push_ok, drop, pop_ok, at_lvl;
  rxq_stat_t         stat_q;
  rxq_ev_t           ev_q;

  assign full_now  = (cnt == CNT_W'(DEPTH));
  assign empty_now = (cnt == '0);
  assign push_ok   = push_i && !full_now;
  assign drop      = push_i && full_now;
  assign pop_ok    = pop_i && !empty_now;
  assign cnt_nx    = cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
  assign at_lvl    = (CMP_W'(cnt_nx) >= CMP_W'(lvl_i));

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem[wptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      stat_q <= '{empty: 1'b1, full: 1'b0, ovr: 1'b0, trig: 1'b0};
      ev_q   <= '0;
    end else if (clr_i) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      stat_q <= '{empty: 1'b1, full: 1'b0, ovr: 1'b0, trig: 1'b0};
      ev_q   <= '0;
    end else begin
      ev_q <= '0;
      if (push_ok) wptr <= ptr_inc(wptr);
      if (pop_ok)  rptr <= ptr_inc(rptr);
      cnt <= cnt_nx;
      // overrun set wins over same-cycle pop clear
      if (drop) begin
        stat_q.ovr <= 1'b1;
        ev_q.ovr   <= 1'b1;
      end else if (pop_i) stat_q.ovr <= 1'b0;
      if (push_ok && cnt_nx == CNT_W'(DEPTH)) begin
        stat_q.full <= 1'b1;
        ev_q.full   <= 1'b1;
      end else if (pop_i) stat_q.full <= 1'b0;
      if (push_ok) stat_q.empty <= 1'b0;
      else if (pop_i && cnt_nx == '0) stat_q.empty <= 1'b1;
      if (push_ok && at_lvl) begin
        stat_q.trig <= 1'b1;
        ev_q.trig   <= 1'b1;
      end else if (pop_i && !at_lvl) stat_q.trig <= 1'b0;
    end
  end

  assign rd_data_o = empty_now ? '0 : mem[rptr];
  assign push_ok_o = push_ok && !clr_i;
  assign stat_o    = stat_q;
  assign ev_o      = ev_q;

  // R4
  full_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q.full == (cnt == CNT_W'(DEPTH)));
  // R7
  empty_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q.empty == (cnt == '0));
  // R3
  ovr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_now && !clr_i) |=> (stat_q.ovr && ev_q.ovr && $stable(wptr)));
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i && !clr_i) |=> ($stable(cnt) && $stable(stat_q)));
  // R12
  simul_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !clr_i && !empty_now && !full_now) |=> $stable(cnt));
endmodule

// File: rtl/uart_rxq_tmo.sv
module uart_rxq_tmo
  import uart_rxq_pkg::*;
#(
  parameter int unsigned CT_W = RXQ_CT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            kick_i,
  input  logic [CT_W-1:0] char_time_i,
  output logic            tmo_o,
  output logic            ev_o
);
  localparam int unsigned TW = CT_W + 2;

  logic [TW-1:0] load, tcnt;
  logic          run;

  assign load = {char_time_i, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run   <= 1'b0;
      tcnt  <= '0;
      tmo_o <= 1'b0;
      ev_o  <= 1'b0;
    end else if (clr_i) begin
      run   <= 1'b0;
      tcnt  <= '0;
      tmo_o <= 1'b0;
      ev_o  <= 1'b0;
    end else begin
      ev_o <= 1'b0;
      if (kick_i) begin
        run  <= (load != '0);
        tcnt <= load;
      end else if (run) begin
        if (tcnt == TW'(1)) begin
          run   <= 1'b0;
          tmo_o <= 1'b1;
          ev_o  <= 1'b1;
        end else begin
          tcnt <= tcnt - TW'(1);
        end
      end
    end
  end

  // R9
  tmo_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && !clr_i) |=> !ev_o);
  // R9
  tmo_ev_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |-> tmo_o);
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH   = RXQ_DEPTH,
  parameter int unsigned DATA_W  = RXQ_DATA_W,
  parameter int unsigned LVL_W   = RXQ_LVL_W,
  parameter int unsigned CT_W    = RXQ_CT_W,
  parameter int unsigned LVL_RST = RXQ_LVL_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              path_rst_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic              lvl_wr_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [CT_W-1:0]   char_time_i,
  output logic              empty_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              trig_o,
  output logic              timeout_o,
  output logic              full_ev_o,
  output logic              overrun_ev_o,
  output logic              trig_ev_o,
  output logic              timeout_ev_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             push_g, pop_g, push_ok;
  rxq_stat_t        stat;
  rxq_ev_t          ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lvl_q <= LVL_W'(LVL_RST);
    else if (lvl_wr_i) lvl_q <= lvl_i;
  end

  assign push_g = enable_i && push_i;
  assign pop_g  = enable_i && pop_i;

  uart_rxq_store #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .LVL_W (LVL_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (path_rst_i),
    .push_i   (push_g),
    .pop_i    (pop_g),
    .data_i   (push_data_i),
    .lvl_i    (lvl_q),
    .rd_data_o(pop_data_o),
    .push_ok_o(push_ok),
    .stat_o   (stat),
    .ev_o     (ev)
  );

  uart_rxq_tmo #(
    .CT_W(CT_W)
  ) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (path_rst_i),
    .kick_i     (push_ok),
    .char_time_i(char_time_i),
    .tmo_o      (timeout_o),
    .ev_o       (timeout_ev_o)
  );

  assign empty_o      = stat.empty;
  assign full_o       = stat.full;
  assign overrun_o    = stat.ovr;
  assign trig_o       = stat.trig;
  assign full_ev_o    = ev.full;
  assign overrun_ev_o = ev.ovr;
  assign trig_ev_o    = ev.trig;

  // R10
  path_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_rst_i |=> (empty_o && !full_o && !overrun_o && !trig_o && !timeout_o));
  // R8
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (pop_data_o == '0));
endmodule

// File: tb/uart_rxq_test.sv
module uart_rxq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0, prst = 1'b0, psh = 1'b0, pp = 1'b0, lwr = 1'b0;
  logic [7:0]  din = '0;
  logic [5:0]  lv = '0;
  logic [15:0] ct = '0;
  logic [7:0]  dout;
  logic        empty, full, ovr, trig, tmo, e_full, e_ovr, e_trig, e_tmo;

  int n_chk = 0, n_err = 0;

  // bench model state
  logic [7:0] q [16];
  int m_cnt, m_rp, m_wp, m_lvl, m_tc;
  bit m_empty, m_full, m_ovr, m_trig, m_tmo, m_run;
  bit x_full, x_ovr, x_trig, x_tmo;

  always #5ns clk = ~clk;

  uart_rxq uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(en), .path_rst_i(prst),
    .push_i(psh), .push_data_i(din), .pop_i(pp), .pop_data_o(dout),
    .lvl_wr_i(lwr), .lvl_i(lv), .char_time_i(ct),
    .empty_o(empty), .full_o(full), .overrun_o(ovr), .trig_o(trig),
    .timeout_o(tmo), .full_ev_o(e_full), .overrun_ev_o(e_ovr),
    .trig_ev_o(e_trig), .timeout_ev_o(e_tmo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_rp = 0; m_wp = 0; m_tc = 0; m_run = 0;
    m_empty = 1; m_full = 0; m_ovr = 0; m_trig = 0; m_tmo = 0;
    x_full = 0; x_ovr = 0; x_trig = 0; x_tmo = 0;
  endtask

  task automatic model_step();
    bit pok, qok, drop;
    int nc;
    x_full = 0; x_ovr = 0; x_trig = 0; x_tmo = 0;
    if (prst) begin
      m_cnt = 0; m_rp = 0; m_wp = 0; m_tc = 0; m_run = 0;
      m_empty = 1; m_full = 0; m_ovr = 0; m_trig = 0; m_tmo = 0;
    end else begin
      pok = en && psh && m_cnt < 16;
      drop = en && psh && m_cnt == 16;
      qok = en && pp && m_cnt > 0;
      if (en) begin
        if (pok) begin q[m_wp] = din; m_wp = (m_wp + 1) % 16; end
        if (qok) m_rp = (m_rp + 1) % 16;
        nc = m_cnt + int'(pok) - int'(qok);
        if (drop) begin m_ovr = 1; x_ovr = 1; end else if (pp) m_ovr = 0;
        if (pok && nc == 16) begin m_full = 1; x_full = 1; end else if (pp) m_full = 0;
        if (pok) m_empty = 0; else if (pp && nc == 0) m_empty = 1;
        if (pok && nc >= m_lvl) begin m_trig = 1; x_trig = 1; end
        else if (pp && nc < m_lvl) m_trig = 0;
        m_cnt = nc;
      end
      if (pok) begin
        m_run = (ct != 0);
        m_tc = 4 * int'(ct);
      end else if (m_run) begin
        if (m_tc == 1) begin m_run = 0; m_tmo = 1; x_tmo = 1; end
        else m_tc--;
      end
    end
    if (lwr) m_lvl = int'(lv);
  endtask

  task automatic compare_all();
    chk("R2 pop_data", int'(dout), (m_cnt == 0) ? 0 : int'(q[m_rp]));
    chk("R7 empty", int'(empty), int'(m_empty));
    chk("R4 full", int'(full), int'(m_full));
    chk("R3 overrun", int'(ovr), int'(m_ovr));
    chk("R5 trig", int'(trig), int'(m_trig));
    chk("R9 timeout", int'(tmo), int'(m_tmo));
    chk("R4 full_ev", int'(e_full), int'(x_full));
    chk("R3 overrun_ev", int'(e_ovr), int'(x_ovr));
    chk("R5 trig_ev", int'(e_trig), int'(x_trig));
    chk("R9 timeout_ev", int'(e_tmo), int'(x_tmo));
  endtask

  // called at a negedge: check, drive, advance one edge
  task automatic cyc(input bit e, input bit r, input bit p, input logic [7:0] d,
                     input bit o, input bit w, input logic [5:0] l);
    compare_all();
    en = e; prst = r; psh = p; din = d; pp = o; lwr = w; lv = l;
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 8'h00, 0, 0, 6'd0);
  endtask

  initial begin
    #(200000 * 10ns);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    m_lvl = 32;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 trig", int'(trig), 0);
    chk("R1 pop_data", int'(dout), 0);

    // fill to 16 with default level 32
    for (int i = 0; i < 16; i++) cyc(1, 0, 1, 8'(8'h40 + i), 0, 0, 6'd0);
    chk("R13 level 32 never reached", int'(trig), 0);
    chk("R4 full at 16", int'(full), 1);
    chk("R1 trig_ev never", int'(e_trig), 0);
    cyc(1, 0, 1, 8'hEE, 0, 0, 6'd0);
    chk("R3 overrun on full push", int'(ovr), 1);
    cyc(1, 0, 1, 8'hDD, 1, 0, 6'd0);
    chk("R3 push+pop on full keeps overrun", int'(ovr), 1);
    chk("R3 push+pop on full pops", int'(full), 0);
    chk("R2 head after one pop", int'(dout), 8'h41);
    cyc(1, 0, 0, 8'h00, 1, 0, 6'd0);
    chk("R7 pop clears overrun", int'(ovr), 0);
    for (int i = 0; i < 14; i++) cyc(1, 0, 0, 8'h00, 1, 0, 6'd0);
    chk("R7 empty after drain", int'(empty), 1);
    cyc(1, 0, 0, 8'h00, 1, 0, 6'd0);
    chk("R8 pop empty returns zero", int'(dout), 0);
    chk("R7 pop on empty keeps empty", int'(empty), 1);

    // trigger level 4
    cyc(1, 0, 1, 8'h11, 0, 1, 6'd4);
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 8'(8'h12 + i), 0, 0, 6'd0);
    chk("R13 level write takes effect", int'(trig), 1);
    chk("R5 trig_ev at level", int'(e_trig), 1);
    cyc(1, 0, 0, 8'h00, 1, 0, 6'd0);
    chk("R6 trig cleared below level", int'(trig), 0);
    cyc(1, 0, 1, 8'h77, 1, 0, 6'd0);
    chk("R12 push+pop head", int'(dout), 8'h13);

    // disabled path
    cyc(0, 0, 1, 8'h99, 1, 0, 6'd0);
    chk("R11 disabled pop/push ignored", int'(dout), 8'h13);
    chk("R11 disabled empty unchanged", int'(empty), 0);

    // path reset
    cyc(1, 1, 1, 8'h55, 0, 0, 6'd0);
    chk("R10 empty", int'(empty), 1);
    chk("R10 pop_data", int'(dout), 0);
    chk("R10 trig", int'(trig), 0);

    // timeout: char time 3 -> 12 cycles
    ct = 16'd3;
    idle(20);
    chk("R9 idle after path reset", int'(tmo), 0);
    cyc(1, 0, 1, 8'hA5, 0, 0, 6'd0);
    idle(11);
    chk("R9 not yet at 11", int'(tmo), 0);
    idle(1);
    chk("R9 fires at 12", int'(tmo), 1);
    chk("R9 event at 12", int'(e_tmo), 1);
    cyc(1, 1, 0, 8'h00, 0, 0, 6'd0);
    chk("R10 timeout cleared", int'(tmo), 0);

    // random traffic
    ct = 16'd2;
    for (int i = 0; i < 4000; i++) begin
      automatic int r = int'($urandom % 100);
      cyc(r < 92, ($urandom % 100) < 2, ($urandom % 100) < 55, 8'($urandom),
          ($urandom % 100) < 40, ($urandom % 100) < 4, 6'($urandom % 20));
    end
    compare_all();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule